// File: doc/BRIEF.md
# PFC Power-Stage Start-Up Supervisor

This block sequences the start-up and protection of a totem-pole power-factor-correction stage whose bulk capacitor is pre-charged through a thyristor-based inrush limiter. It waits for the board supply. On a run request it enables the thyristor soft charge of the DC bus. Once the capacitor reports charged, it starts the PFC switches and ramps the bus voltage reference upward from the measured line peak. When the bus reaches its target, it settles in normal running.

A fault seen in any running state shuts every enable off. The machine moves back to standby when the fault clears.

Loss of the AC line is timed in clock cycles. A short gap leaves the stage untouched, so it rides through. A gap that reaches the limit drops the stage back into the thyristor charge phase, so the soft start repeats when the line comes back. The control loops, PWM generation and analog sensing sit outside this block.

Top module: `pfc_supervisor`

## Requirements
- R1: While reset is held and right after it, `stateOut` is 0 (init), all three enables are low and `vRef` is 0.
- R2: State codes are init 0, standby 1, charge 2, soft start 3, run 4, fault 5. Init moves to standby on `supplyOk`, and standby moves to charge on `runReq`, each one clock after the input is sampled high.
- R3: In charge, `iclEn` is high and `pfcEn` is low. When `capCharged` is high the machine enters soft start, and `vRef` is loaded with the smaller of `linePeak` and TARGET.
- R4: In soft start, `iclEn`, `pfcEn` and `rampEn` are all high. After n clock edges in soft start, `vRef` equals min(start + STEP*floor(n/RAMP_DIV), TARGET).
- R5: `busAtTarget` in soft start moves the machine to run. In run, `rampEn` is low, both other enables are high, and `vRef` holds its value.
- R6: `faultIn` in charge, soft start or run moves the machine to fault on the next clock. This has priority over every other transition in that cycle. In fault, all enables are low and `vRef` is unchanged.
- R7: Fault stays put, and `runReq` is ignored, while `faultIn` is high. The clock after `faultIn` is low, the machine moves to standby.
- R8: A loss of `linePresent` in a running state that lasts fewer than DROP_LIMIT consecutive cycles changes neither the state nor the enables. The dropout count restarts from zero each time the line returns.
- R9: A loss of `linePresent` lasting DROP_LIMIT consecutive cycles in a running state sends the machine to charge on the DROP_LIMIT-th edge, so `pfcEn` falls and `iclEn` stays high. In charge, a long loss keeps it in charge.
- R10: `faultIn` has no effect in init or standby, and `capCharged` has no effect in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyOk | input | 1 | Board supply is up |
| runReq | input | 1 | Request to start the power stage |
| capCharged | input | 1 | Bulk capacitor charged through the thyristors |
| busAtTarget | input | 1 | Bus voltage has reached its final target |
| faultIn | input | 1 | Fault indication, level sensitive |
| linePresent | input | 1 | AC line voltage is present |
| linePeak | input | W | Measured line peak, in reference units |
| iclEn | output | 1 | Thyristor inrush limiter enable |
| pfcEn | output | 1 | PFC switching enable |
| rampEn | output | 1 | Voltage reference ramp is active |
| vRef | output | W | Bus voltage reference |
| stateOut | output | 3 | Current state code |

## Verification
The bench builds the block with W=10, TARGET=200, STEP=8, RAMP_DIV=4 and DROP_LIMIT=20. With these values the 30 ms dropout window is 20 cycles, so the bench can run dropouts of 19 cycles and of 20 cycles and test both sides of the limit. The same values also let a single soft start reach saturation at 200 from a start of 150. A second soft start begins at 100 and is cut short by the bus target. A third begins from a peak above the target to show the clamp. The bench also drives fault together with a charge report, and fault together with dropout expiry, to show that fault wins.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_STANDBY = 3'd1,
    ST_CHARGE  = 3'd2,
    ST_SOFT    = 3'd3,
    ST_RUN     = 3'd4,
    ST_FAULT   = 3'd5
  } supState_t;

  typedef struct packed {
    logic loadRef;
    logic stepRef;
    logic timerRun;
  } ctrlStrobe_t;

endpackage

// File: rtl/pfc_sup_ctrl.sv
module pfc_sup_ctrl
  import pfc_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        runReq,
  input  logic        capCharged,
  input  logic        busAtTarget,
  input  logic        faultIn,
  input  logic        dropLong,
  output supState_t   state,
  output ctrlStrobe_t strobe,
  output logic        iclEn,
  output logic        pfcEn,
  output logic        rampEn
);

  supState_t nextState;
  logic      running;

  assign running = (state == ST_CHARGE) || (state == ST_SOFT) || (state == ST_RUN);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_INIT:    if (supplyOk)    nextState = ST_STANDBY;
      ST_STANDBY: if (runReq)      nextState = ST_CHARGE;
      ST_CHARGE:  if (capCharged)  nextState = ST_SOFT;
      ST_SOFT:    if (busAtTarget) nextState = ST_RUN;
      ST_RUN:     nextState = ST_RUN;
      ST_FAULT:   if (!faultIn)    nextState = ST_STANDBY;
      default:    nextState = ST_INIT;
    endcase
    // a long line loss overrides the normal sequence
    if (running && dropLong) nextState = ST_CHARGE;
    // fault overrides everything
    if (running && faultIn) nextState = ST_FAULT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= nextState;
  end

  always_comb begin
    strobe.loadRef  = (state == ST_CHARGE) && (nextState == ST_SOFT);
    strobe.stepRef  = (state == ST_SOFT);
    strobe.timerRun = running;
  end

  always_comb begin
    iclEn  = running;
    pfcEn  = (state == ST_SOFT) || (state == ST_RUN);
    rampEn = (state == ST_SOFT);
  end

endmodule

// File: rtl/pfc_sup_dp.sv
module pfc_sup_dp
  import pfc_sup_pkg::*;
#(
  parameter int W          = 12,
  parameter int TARGET     = 3200,
  parameter int STEP       = 1,
  parameter int RAMP_DIV   = 1000,
  parameter int DROP_LIMIT = 3000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        linePresent,
  input  logic [W-1:0] linePeak,
  output logic [W-1:0] vRef,
  output logic        dropLong
);

  localparam int DW = $clog2(DROP_LIMIT + 1);
  localparam logic [DW-1:0] DROP_LAST = DW'(DROP_LIMIT - 1);
  localparam logic [DW-1:0] DROP_CAP  = DW'(DROP_LIMIT);
  localparam logic [W-1:0]  TGT       = W'(TARGET);
  localparam logic [W:0]    TGT_EXT   = (W+1)'(TARGET);
  localparam logic [W:0]    STEP_EXT  = (W+1)'(STEP);

  // line dropout timer
  logic [DW-1:0] dropCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               dropCnt <= '0;
    else if (!strobe.timerRun || linePresent) dropCnt <= '0;
    else if (dropCnt != DROP_CAP)            dropCnt <= dropCnt + 1'b1;
  end

  assign dropLong = strobe.timerRun && !linePresent && (dropCnt == DROP_LAST);

  // ramp pacing: one step every RAMP_DIV cycles
  logic stepTick;

  generate
    if (RAMP_DIV > 1) begin : g_div
      localparam int RW = $clog2(RAMP_DIV);
      localparam logic [RW-1:0] DIV_LAST = RW'(RAMP_DIV - 1);
      logic [RW-1:0] divCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               divCnt <= '0;
        else if (strobe.loadRef || !strobe.stepRef) divCnt <= '0;
        else if (divCnt == DIV_LAST)             divCnt <= '0;
        else                                     divCnt <= divCnt + 1'b1;
      end

      assign stepTick = strobe.stepRef && (divCnt == DIV_LAST);
    end else begin : g_nodiv
      assign stepTick = strobe.stepRef;
    end
  endgenerate

  // saturating reference
  logic [W:0]   stepSum;
  logic [W-1:0] startRef;

  assign stepSum  = {1'b0, vRef} + STEP_EXT;
  assign startRef = (linePeak >= TGT) ? TGT : linePeak;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vRef <= '0;
    else if (strobe.loadRef) vRef <= startRef;
    else if (stepTick)       vRef <= (stepSum >= TGT_EXT) ? TGT : stepSum[W-1:0];
  end

endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int W          = 12,
  parameter int TARGET     = 3200,
  parameter int STEP       = 1,
  parameter int RAMP_DIV   = 1000,
  parameter int DROP_LIMIT = 3000000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyOk,
  input  logic         runReq,
  input  logic         capCharged,
  input  logic         busAtTarget,
  input  logic         faultIn,
  input  logic         linePresent,
  input  logic [W-1:0] linePeak,
  output logic         iclEn,
  output logic         pfcEn,
  output logic         rampEn,
  output logic [W-1:0] vRef,
  output logic [2:0]   stateOut
);

  supState_t   state;
  ctrlStrobe_t strobe;
  logic        dropLong;

  pfc_sup_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .supplyOk    (supplyOk),
    .runReq      (runReq),
    .capCharged  (capCharged),
    .busAtTarget (busAtTarget),
    .faultIn     (faultIn),
    .dropLong    (dropLong),
    .state       (state),
    .strobe      (strobe),
    .iclEn       (iclEn),
    .pfcEn       (pfcEn),
    .rampEn      (rampEn)
  );

  pfc_sup_dp #(
    .W          (W),
    .TARGET     (TARGET),
    .STEP       (STEP),
    .RAMP_DIV   (RAMP_DIV),
    .DROP_LIMIT (DROP_LIMIT)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .linePresent (linePresent),
    .linePeak    (linePeak),
    .vRef        (vRef),
    .dropLong    (dropLong)
  );

  assign stateOut = state;

endmodule

// File: rtl/pfc_supervisor_chk.sv
module pfc_supervisor_chk #(
  parameter int W      = 12,
  parameter int TARGET = 3200
) (
  input logic         clk,
  input logic         rstN,
  input logic         faultIn,
  input logic         linePresent,
  input logic         busAtTarget,
  input logic         iclEn,
  input logic         pfcEn,
  input logic         rampEn,
  input logic [W-1:0] vRef,
  input logic [2:0]   stateOut
);

  logic inRun;
  assign inRun = (stateOut == 3'd2) || (stateOut == 3'd3) || (stateOut == 3'd4);

  // R6
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && faultIn) |=> (stateOut == 3'd5));

  // R6
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd5) |-> (!iclEn && !pfcEn && !rampEn));

  // R4
  ref_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vRef <= W'(TARGET));

  // R4
  ref_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd3) |=> (vRef >= $past(vRef)));

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateOut == 3'd4) && !faultIn) |=> $stable(vRef));

  // R8
  line_ok_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateOut == 3'd4) && linePresent && !faultIn) |=> (stateOut == 3'd4));

  // R7
  fault_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateOut == 3'd5) && !faultIn) |=> (stateOut == 3'd1));

  // R5
  soft_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateOut == 3'd3) && busAtTarget && !faultIn && linePresent) |=> (stateOut == 3'd4));

endmodule

bind pfc_supervisor pfc_supervisor_chk #(
  .W      (W),
  .TARGET (TARGET)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .faultIn     (faultIn),
  .linePresent (linePresent),
  .busAtTarget (busAtTarget),
  .iclEn       (iclEn),
  .pfcEn       (pfcEn),
  .rampEn      (rampEn),
  .vRef        (vRef),
  .stateOut    (stateOut)
);

// File: tb/test_pfc_supervisor.sv
module test_pfc_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int TARGET     = 200;
  localparam int STEP       = 8;
  localparam int RAMP_DIV   = 4;
  localparam int DROP_LIMIT = 20;

  localparam int S_INIT = 0, S_STBY = 1, S_CHG = 2, S_SOFT = 3, S_RUN = 4, S_FLT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 0, runReq = 0, capCharged = 0, busAtTarget = 0, faultIn = 0;
  logic linePresent = 1;
  logic [W-1:0] linePeak = '0;
  logic iclEn, pfcEn, rampEn;
  logic [W-1:0] vRef;
  logic [2:0] stateOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_supervisor #(
    .W(W), .TARGET(TARGET), .STEP(STEP), .RAMP_DIV(RAMP_DIV), .DROP_LIMIT(DROP_LIMIT)
  ) i_pfc_supervisor (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .runReq(runReq),
    .capCharged(capCharged), .busAtTarget(busAtTarget), .faultIn(faultIn),
    .linePresent(linePresent), .linePeak(linePeak),
    .iclEn(iclEn), .pfcEn(pfcEn), .rampEn(rampEn), .vRef(vRef), .stateOut(stateOut)
  );

  typedef struct {
    int    st;
    int    refVal;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  function automatic logic [2:0] enablesFor(int st);
    // {icl, pfc, ramp} per R3, R4, R5, R6
    case (st)
      S_CHG:   return 3'b100;
      S_SOFT:  return 3'b111;
      S_RUN:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  task automatic compare(int st, int refVal, string tag);
    logic [2:0] en;
    en = enablesFor(st);
    testsRun++;
    if (stateOut !== 3'(st) || {iclEn, pfcEn, rampEn} !== en || vRef !== W'(refVal)) begin
      testsFailed++;
      $display("FAIL %s: state=%0d en=%b vRef=%0d expected state=%0d en=%b vRef=%0d",
               tag, stateOut, {iclEn, pfcEn, rampEn}, vRef, st, en, refVal);
    end
  endtask

  // monitor: outputs are sampled at the falling edge after each driven rising edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      cur = expQ.pop_front();
      compare(cur.st, cur.refVal, cur.tag);
    end
  end

  // driver: inputs already set; one clock edge, then queue the expected result
  task automatic tick(int st, int refVal, string tag);
    expItem_t e;
    @(posedge clk);
    e.st = st; e.refVal = refVal; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  function automatic int rampVal(int start, int n);
    int v;
    v = start + STEP * (n / RAMP_DIV);
    return (v > TARGET) ? TARGET : v;
  endfunction

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 20000", cyc);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    compare(S_INIT, 0, "R1");
    rstN = 1'b1;

    // R10 fault ignored in init, init waits for the supply
    faultIn = 1;
    tick(S_INIT, 0, "R10");
    tick(S_INIT, 0, "R10");
    faultIn = 0;
    supplyOk = 1;
    tick(S_STBY, 0, "R2");
    tick(S_STBY, 0, "R2");
    // R10 fault and charge report ignored in standby
    faultIn = 1;
    tick(S_STBY, 0, "R10");
    faultIn = 0;
    capCharged = 1;
    tick(S_STBY, 0, "R10");
    capCharged = 0;
    runReq = 1;
    tick(S_CHG, 0, "R2");
    runReq = 0;
    linePeak = 150;
    tick(S_CHG, 0, "R3");

    // R9 long loss while charging keeps the charge state
    linePresent = 0;
    for (int i = 0; i < 25; i++) tick(S_CHG, 0, "R9");
    linePresent = 1;

    // R3 entry into soft start loads the line peak
    capCharged = 1;
    tick(S_SOFT, 150, "R3");
    capCharged = 0;
    // R4 ramp up to saturation
    for (int n = 1; n <= 30; n++) tick(S_SOFT, rampVal(150, n), "R4");
    busAtTarget = 1;
    tick(S_RUN, 200, "R5");
    busAtTarget = 0;
    for (int i = 0; i < 3; i++) tick(S_RUN, 200, "R5");

    // R8 two short losses separated by line return
    linePresent = 0;
    for (int i = 0; i < DROP_LIMIT - 1; i++) tick(S_RUN, 200, "R8");
    linePresent = 1;
    tick(S_RUN, 200, "R8");
    linePresent = 0;
    for (int i = 0; i < DROP_LIMIT - 1; i++) tick(S_RUN, 200, "R8");
    linePresent = 1;
    tick(S_RUN, 200, "R8");

    // R9 loss reaching the limit returns to charge
    linePresent = 0;
    for (int i = 0; i < DROP_LIMIT - 1; i++) tick(S_RUN, 200, "R9");
    tick(S_CHG, 200, "R9");
    for (int i = 0; i < 3; i++) tick(S_CHG, 200, "R9");
    linePresent = 1;
    tick(S_CHG, 200, "R9");

    // R3/R4/R5 second soft start cut short by the bus target
    linePeak = 100;
    capCharged = 1;
    tick(S_SOFT, 100, "R3");
    capCharged = 0;
    for (int n = 1; n <= 6; n++) tick(S_SOFT, rampVal(100, n), "R4");
    busAtTarget = 1;
    tick(S_RUN, rampVal(100, 7), "R5");
    busAtTarget = 0;
    tick(S_RUN, 108, "R5");
    tick(S_RUN, 108, "R5");

    // R6/R7 fault from run, run request ignored while faulted
    faultIn = 1;
    tick(S_FLT, 108, "R6");
    tick(S_FLT, 108, "R7");
    runReq = 1;
    tick(S_FLT, 108, "R7");
    runReq = 0;
    faultIn = 0;
    tick(S_STBY, 108, "R7");

    // R6 fault beats the charge report
    runReq = 1;
    tick(S_CHG, 108, "R2");
    runReq = 0;
    capCharged = 1;
    faultIn = 1;
    tick(S_FLT, 108, "R6");
    capCharged = 0;
    faultIn = 0;
    tick(S_STBY, 108, "R7");

    // R3 clamp of a peak above target, then R6 fault beats dropout expiry
    runReq = 1;
    tick(S_CHG, 108, "R2");
    runReq = 0;
    linePeak = 250;
    capCharged = 1;
    tick(S_SOFT, 200, "R3");
    capCharged = 0;
    linePresent = 0;
    for (int i = 0; i < DROP_LIMIT - 1; i++) tick(S_SOFT, 200, "R8");
    faultIn = 1;
    tick(S_FLT, 200, "R6");
    faultIn = 0;
    linePresent = 1;
    tick(S_STBY, 200, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    finishRun();
  end

endmodule